// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Arbiter

This block gathers interrupt requests from a row of source cells onto one request line toward a processor, then settles which cell is served by passing a single acknowledge down the row. Cell 0 sits nearest the processor. The acknowledge enters cell 0. A cell with a pending request keeps the acknowledge and is granted. A cell with nothing pending hands the acknowledge to the next cell. Priority is therefore set only by position in the row, and no central encoder is involved.

Each cell remembers a request until it is served. The set of requesting cells is frozen when the acknowledge rises, so the winner cannot change while the pulse is high. While the acknowledge is high, the granted cell places its 8-bit vector number on a shared bus that is combined with OR. Its pending request is dropped when the pulse ends. If the acknowledge reaches past the last cell with no taker, a flag reports that nobody was granted.

Top module: `irq_chain`

## Requirements
- R1: `irq` is high in any cycle in which some `req` bit is high or some cell has a pending request, and it is low when neither holds.
- R2: A one-cycle pulse on `req[i]` makes cell i pending. Cell i stays pending, and `irq` stays high, until cell i is served.
- R3: The acknowledge enters cell 0. The pending cell with the lowest index is granted, and `grant` is bit-indexed by cell number.
- R4: A granted cell does not pass the acknowledge on, so `no_grant` is low whenever any `grant` bit is high.
- R5: At most one `grant` bit is high, and only while `ack_in` is high.
- R6: While cell i is granted, `vec_bus` equals `VEC_BASE + i` (default `VEC_BASE` = 8'h20). While no cell is granted, `vec_bus` is 0.
- R7: The requesting set is sampled in the first cycle of a high `ack_in`. A request that arrives later in the same pulse does not change `grant`.
- R8: On the first clock edge after `ack_in` falls, only the granted cell's pending request is cleared. Every other pending cell is kept.
- R9: If `ack_in` is high and no cell is requesting, `grant` is 0, `vec_bus` is 0 and `no_grant` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Request from each cell, index 0 nearest the processor |
| ack_in | input | 1 | Acknowledge from the processor into cell 0 |
| irq | output | 1 | OR of all requests to the processor |
| grant | output | N | Granted cell, one-hot or zero |
| vec_bus | output | VW | Vector number of the granted cell |
| no_grant | output | 1 | Acknowledge left the far end of the chain unconsumed |

## Verification
The bench builds the block with N = 4 and VEC_BASE = 8'h20. With only four cells, each cell position, the far-end cell 3, and the empty-chain case can all be reached with short, directed request patterns. Requests on cells 1 and 3 at the same time test the priority and the selective clear. A request on cell 0 raised in the middle of a pulse that cell 3 already holds tests that the grant is frozen.

// File: rtl/irq_chain.sv
module irq_chain #(
  parameter int N = 4,
  parameter int VW = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          ack_in,
  output logic          irq,
  output logic [N-1:0]  grant,
  output logic [VW-1:0] vec_bus,
  output logic          no_grant
);
  logic [N-1:0] pending, snap, grant_q, src;
  logic [N:0]   chain;
  logic         ack_q, rise, fall;

  assign rise = ack_in & ~ack_q;
  assign fall = ack_q & ~ack_in;
  assign src  = rise ? (pending | req) : snap;
  assign irq  = |(pending | req);

  assign chain[0] = ack_in;
  for (genvar i = 0; i < N; i++) begin : g_cell
    assign grant[i]   = chain[i] & src[i];
    assign chain[i+1] = chain[i] & ~src[i];
  end
  assign no_grant = chain[N];

  always_comb begin
    vec_bus = '0;
    for (int i = 0; i < N; i++)
      vec_bus = vec_bus | (grant[i] ? VW'(VEC_BASE + VW'(i)) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      snap    <= '0;
      grant_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q   <= ack_in;
      grant_q <= grant;
      if (rise) snap <= pending | req;
      pending <= (pending | req) & ~(fall ? grant_q : '0);
    end
  end
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int N = 4,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic          ack_in,
  input logic          irq,
  input logic [N-1:0]  grant,
  input logic [VW-1:0] vec_bus,
  input logic          no_grant
);
  assert_req_raises_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> irq);
  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ack_in);
  assert_consumed_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> !no_grant);
  assert_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (vec_bus == '0));
  assert_grant_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && $past(ack_in)) |-> $stable(grant));
endmodule

bind irq_chain irq_chain_chk #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack_in(ack_in), .irq(irq),
  .grant(grant), .vec_bus(vec_bus), .no_grant(no_grant)
);

// File: tb/sim_irq_chain.sv
module sim_irq_chain;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, ack_in = 0;
  logic [N-1:0] req = '0;
  logic irq, no_grant;
  logic [N-1:0] grant;
  logic [7:0] vec_bus;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_chain #(.N(N), .VW(8), .VEC_BASE(8'h20)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .ack_in(ack_in), .irq(irq),
    .grant(grant), .vec_bus(vec_bus), .no_grant(no_grant)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic pulse_req(logic [N-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0; #2;
  endtask

  task automatic ack_up();
    @(negedge clk); ack_in = 1; #2;
  endtask

  task automatic ack_down();
    @(negedge clk); ack_in = 0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset irq", irq, 0);
    chk("R5 reset grant", grant, 0);
    chk("R6 reset vec", vec_bus, 0);
    chk("R9 reset no_grant", no_grant, 0);
  endtask

  task automatic t_live_irq();
    @(negedge clk); req = 4'b0001; #2;
    chk("R1 live irq", irq, 1);
    @(negedge clk); req = '0; #2;
    ack_up();
    chk("R3 cell0 grant", grant, 4'b0001);
    chk("R6 cell0 vec", vec_bus, 8'h20);
    ack_down();
    chk("R1 irq idle", irq, 0);
  endtask

  task automatic t_single();
    pulse_req(4'b0100);
    step();
    chk("R2 held pending", irq, 1);
    ack_up();
    chk("R3 cell2 grant", grant, 4'b0100);
    chk("R6 cell2 vec", vec_bus, 8'h22);
    chk("R4 consumed", no_grant, 0);
    ack_down();
    chk("R8 cleared", irq, 0);
    chk("R5 no grant after ack", grant, 0);
  endtask

  task automatic t_priority();
    pulse_req(4'b1010);
    ack_up();
    chk("R3 near wins", grant, 4'b0010);
    chk("R5 one grant", $countones(grant), 1);
    chk("R6 cell1 vec", vec_bus, 8'h21);
    ack_down();
    chk("R8 other kept", irq, 1);
    ack_up();
    chk("R3 far cell", grant, 4'b1000);
    chk("R6 cell3 vec", vec_bus, 8'h23);
    ack_down();
    chk("R8 all served", irq, 0);
  endtask

  task automatic t_snapshot();
    pulse_req(4'b1000);
    ack_up();
    chk("R7 initial grant", grant, 4'b1000);
    @(negedge clk); req = 4'b0001;
    @(negedge clk); req = '0; #2;
    chk("R7 grant frozen", grant, 4'b1000);
    chk("R7 vec frozen", vec_bus, 8'h23);
    ack_down();
    chk("R8 late req kept", irq, 1);
    ack_up();
    chk("R7 late req served next", grant, 4'b0001);
    ack_down();
    chk("R8 empty", irq, 0);
  endtask

  task automatic t_none();
    ack_up();
    chk("R9 no_grant", no_grant, 1);
    chk("R9 grant zero", grant, 0);
    chk("R9 vec zero", vec_bus, 0);
    ack_down();
    chk("R9 flag drops", no_grant, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1; #2;
        t_reset();
        t_live_irq();
        t_single();
        t_priority();
        t_snapshot();
        t_none();
      end
      begin
        repeat (2000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule